// File: doc/BRIEF.md
# Guarded Register Access Sequencer

This block takes single register requests (read, write, set-bits, clear-bits) from a local requester and turns each into one or more transactions on a downstream 64-bit register bus. On a silicon revision that can lock up when certain low register offsets are touched, it surrounds each such access with dummy reads at companion offsets, chosen from the target offset. On other revisions, or for offsets above the guarded window, the access goes out unchanged.

Set-bits and clear-bits are read-modify-write operations. Each is run as a guarded read of the target, a merge of the mask into the value read, and a guarded write of the merged value. The requester sees ready drop while the sequence runs, a one-cycle done pulse at the end, and the value read by the real access on the read data output.

Top module: `reg_guard_seq`

## Requirements
- R1: With `rev_a` low at acceptance, every command issues only its real transactions at the request offset: one for read or write, a read then a write for set-bits and clear-bits.
- R2: With `rev_a` high, a target offset of 0x45000 or above is accessed with no dummy transactions; offset 0x44FF8 is still guarded.
- R3: A guarded pass starts with a dummy read at offset 0xC0 for targets 0x0 and 0x80, at 0x28 for targets 0x148 and 0x200, and at 0x158 for every other guarded target.
- R4: In a guarded pass whose target is 0x100, a dummy read of offset 0x38 follows the real access.
- R5: Every guarded pass ends with a dummy read of offset 0xB050, after any extra read of R4.
- R6: All dummy transactions are reads (`bus_write` low), and their returned data never reaches `rd_data`.
- R7: Set-bits (`req_cmd` = 2) reads the target, then writes back the value read ORed with `req_wdata`; each of the two passes is guarded on its own.
- R8: Clear-bits (`req_cmd` = 3) reads the target, then writes back the value read ANDed with the inverse of `req_wdata`; each pass is guarded on its own.
- R9: Transactions go out one at a time: while `bus_valid` is high and `bus_ack` low, address, direction and write data stay unchanged in the next cycle.
- R10: `req_ready` is high only when idle; after acceptance it stays low until the cycle after a single-cycle `done` pulse.
- R11: After a read (`req_cmd` = 0), set-bits or clear-bits, `rd_data` shows the data of the real read of the target and holds it until the next acceptance; a write clears it to zero.
- R12: A write (`req_cmd` = 1) drives `req_wdata` unchanged on `bus_wdata` during its real transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rev_a | input | 1 | High when the target has the revision that needs guarding; sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_cmd | input | 2 | 0 read, 1 write, 2 set-bits, 3 clear-bits |
| req_addr | input | ADDR_W | Target offset from the register base |
| req_wdata | input | DATA_W | Write data, or mask for set/clear |
| done | output | 1 | One-cycle pulse when the sequence has finished |
| rd_data | output | DATA_W | Data of the real read, held until the next acceptance |
| bus_valid | output | 1 | Downstream transaction present |
| bus_write | output | 1 | Downstream transaction is a write |
| bus_addr | output | ADDR_W | Downstream offset |
| bus_wdata | output | DATA_W | Downstream write data |
| bus_ack | input | 1 | Downstream completes the present transaction |
| bus_rdata | input | DATA_W | Downstream read data, valid with `bus_ack` |

## Verification
Directed requests hit each target class that selects a different leading dummy offset, the 0x100 target that adds an extra trailing read, and both sides of the 0x45000 window edge, each with the revision flag set and clear, so a wrong offset table or wrong window compare shows up as a mismatched transaction list. Set-bits and clear-bits run on guarded and unguarded targets, which separates the two merge operations and checks that both passes are guarded independently. A random mix of commands, offsets, revision flags and acknowledge delays of zero to three cycles then checks that the transaction list, write data and held read data stay correct when acknowledges arrive at varying times; the downstream model returns distinct data for dummy offsets so a leak into `rd_data` is visible.

// File: rtl/reg_guard_pkg.sv
package reg_guard_pkg;

    typedef enum logic [1:0] {
        CMD_RD  = 2'd0,
        CMD_WR  = 2'd1,
        CMD_SET = 2'd2,
        CMD_CLR = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_MAIN,
        ST_POST_A,
        ST_POST_B,
        ST_FIN
    } seq_e;

    typedef struct packed {
        logic        guarded;
        logic        extra_post;
        logic [15:0] pre_off;
    } guard_plan_t;

    localparam int          DEFAULT_GUARD_LIMIT = 'h45000;
    localparam logic [15:0] EXTRA_TRIGGER_OFF   = 16'h0100;
    localparam logic [15:0] EXTRA_POST_OFF      = 16'h0038;
    localparam logic [15:0] FINAL_POST_OFF      = 16'hB050;

    function automatic logic [15:0] pre_dummy_off(input logic [31:0] off);
        case (off)
            32'h0000_0000, 32'h0000_0080: return 16'h00C0;
            32'h0000_0148, 32'h0000_0200: return 16'h0028;
            default:                      return 16'h0158;
        endcase
    endfunction

endpackage

// File: rtl/guard_plan.sv
module guard_plan
    import reg_guard_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LIMIT  = DEFAULT_GUARD_LIMIT
) (
    input  logic              rev_a,
    input  logic [ADDR_W-1:0] offset,
    output guard_plan_t       plan
);
    localparam logic [ADDR_W-1:0] LIMIT_A   = ADDR_W'(LIMIT);
    localparam logic [ADDR_W-1:0] TRIGGER_A = ADDR_W'(EXTRA_TRIGGER_OFF);

    always_comb begin
        plan.guarded    = rev_a && (offset < LIMIT_A);
        plan.extra_post = (offset == TRIGGER_A);
        plan.pre_off    = pre_dummy_off(32'(offset));
    end
endmodule

// File: rtl/bit_merge.sv
module bit_merge
    import reg_guard_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  cmd_e              cmd,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] merged
);
    always_comb begin
        case (cmd)
            CMD_SET: merged = old_val | mask;
            CMD_CLR: merged = old_val & ~mask;
            default: merged = old_val;
        endcase
    end
endmodule

// File: rtl/reg_guard_seq.sv
module reg_guard_seq
    import reg_guard_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 64,
    parameter int GUARD_LIMIT = DEFAULT_GUARD_LIMIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rev_a,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] EXTRA_A = ADDR_W'(EXTRA_POST_OFF);
    localparam logic [ADDR_W-1:0] FINAL_A = ADDR_W'(FINAL_POST_OFF);

    seq_e              state_q, state_d;
    cmd_e              cmd_q;
    logic [ADDR_W-1:0] off_q;
    logic [DATA_W-1:0] mask_q, wval_q, rd_q, merged;
    guard_plan_t       plan_now, plan_q;
    logic              phase2_q;
    logic              rmw, write_pass, issuing, xfer, pass_done;
    seq_e              pass_next;

    guard_plan #(.ADDR_W(ADDR_W), .LIMIT(GUARD_LIMIT)) u_plan (
        .rev_a  (rev_a),
        .offset (req_addr),
        .plan   (plan_now)
    );

    bit_merge #(.DATA_W(DATA_W)) u_merge (
        .cmd     (cmd_q),
        .old_val (bus_rdata),
        .mask    (mask_q),
        .merged  (merged)
    );

    always_comb begin
        rmw        = (cmd_q == CMD_SET) || (cmd_q == CMD_CLR);
        write_pass = (cmd_q == CMD_WR) || (rmw && phase2_q);
        issuing    = (state_q == ST_PRE) || (state_q == ST_MAIN) ||
                     (state_q == ST_POST_A) || (state_q == ST_POST_B);
        xfer       = issuing && bus_ack;
        pass_done  = xfer && (((state_q == ST_MAIN) && !plan_q.guarded) ||
                              (state_q == ST_POST_B));
        if (rmw && !phase2_q)
            pass_next = plan_q.guarded ? ST_PRE : ST_MAIN;
        else
            pass_next = ST_FIN;
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (req_valid) state_d = plan_now.guarded ? ST_PRE : ST_MAIN;
            ST_PRE:    if (bus_ack) state_d = ST_MAIN;
            ST_MAIN:   if (bus_ack) begin
                           if (!plan_q.guarded)        state_d = pass_next;
                           else if (plan_q.extra_post) state_d = ST_POST_A;
                           else                        state_d = ST_POST_B;
                       end
            ST_POST_A: if (bus_ack) state_d = ST_POST_B;
            ST_POST_B: if (bus_ack) state_d = pass_next;
            ST_FIN:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cmd_q    <= CMD_RD;
            off_q    <= '0;
            mask_q   <= '0;
            wval_q   <= '0;
            rd_q     <= '0;
            plan_q   <= '0;
            phase2_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_IDLE) && req_valid) begin
                cmd_q    <= cmd_e'(req_cmd);
                off_q    <= req_addr;
                mask_q   <= req_wdata;
                wval_q   <= req_wdata;
                rd_q     <= '0;
                plan_q   <= plan_now;
                phase2_q <= 1'b0;
            end
            if ((state_q == ST_MAIN) && bus_ack && !write_pass) begin
                rd_q   <= bus_rdata;
                wval_q <= merged;
            end
            if (pass_done && rmw && !phase2_q)
                phase2_q <= 1'b1;
        end
    end

    always_comb begin
        case (state_q)
            ST_PRE:    bus_addr = ADDR_W'(plan_q.pre_off);
            ST_POST_A: bus_addr = EXTRA_A;
            ST_POST_B: bus_addr = FINAL_A;
            default:   bus_addr = off_q;
        endcase
    end

    assign bus_valid = issuing;
    assign bus_write = (state_q == ST_MAIN) && write_pass;
    assign bus_wdata = wval_q;
    assign req_ready = (state_q == ST_IDLE);
    assign done      = (state_q == ST_FIN);
    assign rd_data   = rd_q;

    // R9: a pending transaction is held until acknowledged
    assert_hold_pending_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr) &&
                                     $stable(bus_write) && $stable(bus_wdata)));

    // R6: writes only happen at the request offset
    assert_write_at_target_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write) |-> (bus_addr == off_q));

    // R10: done lasts one cycle
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: no second acceptance straight after one
    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R10: done follows a downstream acknowledge
    assert_done_after_ack_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bus_ack));

    // R11: read data holds while idle and not accepting
    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !req_valid) |=> $stable(rd_data));

endmodule

// File: tb/test_reg_guard_seq.sv
`timescale 1ns/1ps
module test_reg_guard_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rev_a = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_cmd = 2'd0;
    logic [23:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        done;
    logic [63:0] rd_data;
    logic        bus_valid, bus_write;
    logic [23:0] bus_addr;
    logic [63:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [63:0] bus_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    reg_guard_seq i_reg_guard_seq (
        .clk(clk), .rst(rst), .rev_a(rev_a),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rd_data(rd_data),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    logic [63:0] mem [int];
    logic        lw [32];
    logic [23:0] la [32];
    logic [63:0] ld [32];
    int          lcnt = 0;
    logic        ew [32];
    logic [23:0] ea [32];
    logic [63:0] ed [32];
    string       et [32];
    int          ecnt;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mval(input logic [23:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return {8'hA5, 8'h00, a, 24'h5A5A5A};
    endfunction

    function automatic logic [23:0] exp_pre(input logic [23:0] off);
        if (off == 24'h0 || off == 24'h80) return 24'hC0;
        if (off == 24'h148 || off == 24'h200) return 24'h28;
        return 24'h158;
    endfunction

    function automatic void add_exp(input logic w, input logic [23:0] a,
                                    input logic [63:0] d, input string t);
        ew[ecnt] = w; ea[ecnt] = a; ed[ecnt] = d; et[ecnt] = t;
        ecnt++;
    endfunction

    function automatic void add_pass(input bit g, input logic [23:0] off,
                                     input logic w, input logic [63:0] d,
                                     input string main_tag);
        if (g) add_exp(1'b0, exp_pre(off), 64'h0, "R3");
        add_exp(w, off, d, main_tag);
        if (g && off == 24'h100) add_exp(1'b0, 24'h38, 64'h0, "R4");
        if (g) add_exp(1'b0, 24'hB050, 64'h0, "R5");
    endfunction

    // downstream bus model with random acknowledge delay
    initial begin : bus_model
        int dly;
        bit pend;
        logic [23:0] pa;
        logic pw;
        dly = 0; pend = 0; pa = '0; pw = 1'b0;
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
                pend = 0;
            end else if (bus_valid && !rst) begin
                if (pend)
                    chk(bus_addr == pa && bus_write == pw, "R9", "pending transaction changed",
                        {39'h0, bus_write, bus_addr}, {39'h0, pw, pa});
                pend = 1; pa = bus_addr; pw = bus_write;
                if (dly == 0) begin
                    if (lcnt < 32) begin
                        lw[lcnt] = bus_write; la[lcnt] = bus_addr; ld[lcnt] = bus_wdata;
                    end
                    lcnt++;
                    if (bus_write) mem[int'(bus_addr)] = bus_wdata;
                    else bus_rdata = mval(bus_addr);
                    bus_ack = 1'b1;
                    dly = int'($urandom % 4);
                end else begin
                    dly--;
                end
            end else begin
                pend = 0;
            end
        end
    end

    task automatic run_req(input logic rv, input logic [1:0] op,
                           input logic [23:0] off, input logic [63:0] wd);
        logic [63:0] old;
        logic [63:0] nv;
        logic [63:0] exp_rd;
        bit g;
        bit ready_bad;
        int cyc;
        string mtag;
        string ctag;
        g = rv && (off < 24'h45000);
        old = mval(off);
        mtag = !rv ? "R1" : (off >= 24'h45000 ? "R2" : "R3");
        ecnt = 0;
        case (op)
            2'd0: begin add_pass(g, off, 1'b0, 64'h0, mtag); exp_rd = old; ctag = mtag; end
            2'd1: begin add_pass(g, off, 1'b1, wd, "R12"); exp_rd = 64'h0; ctag = mtag; end
            2'd2: begin
                nv = old | wd;
                add_pass(g, off, 1'b0, 64'h0, "R7");
                add_pass(g, off, 1'b1, nv, "R7");
                exp_rd = old; ctag = "R7";
            end
            default: begin
                nv = old & ~wd;
                add_pass(g, off, 1'b0, 64'h0, "R8");
                add_pass(g, off, 1'b1, nv, "R8");
                exp_rd = old; ctag = "R8";
            end
        endcase
        lcnt = 0;
        @(negedge clk);
        chk(req_ready, "R10", "ready before request", {63'h0, req_ready}, 64'h1);
        rev_a = rv; req_cmd = op; req_addr = off; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rev_a = ~rv;
        cyc = 0; ready_bad = 0;
        while (!done && cyc < 400) begin
            if (req_ready) ready_bad = 1;
            @(negedge clk);
            cyc++;
        end
        if (req_ready) ready_bad = 1;
        chk(!ready_bad && done, "R10", "ready low until done", {63'h0, ready_bad}, 64'h0);
        @(negedge clk);
        chk(!done && req_ready, "R10", "done single cycle then ready",
            {62'h0, done, req_ready}, 64'h1);
        chk(lcnt == ecnt, ctag, "transaction count", 64'(lcnt), 64'(ecnt));
        for (int k = 0; k < ecnt && k < lcnt && k < 32; k++) begin
            chk(lw[k] == ew[k], (et[k] == "R3" || et[k] == "R4" || et[k] == "R5") ? "R6" : et[k],
                "transaction direction", {63'h0, lw[k]}, {63'h0, ew[k]});
            chk(la[k] == ea[k], et[k], "transaction offset", {40'h0, la[k]}, {40'h0, ea[k]});
            if (ew[k])
                chk(ld[k] == ed[k], et[k], "write data", ld[k], ed[k]);
        end
        chk(rd_data == exp_rd, "R11", "read data after sequence (R6 no dummy leak)", rd_data, exp_rd);
        repeat (2) @(negedge clk);
        chk(rd_data == exp_rd, "R11", "read data held while idle", rd_data, exp_rd);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [23:0] off;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !done && !bus_valid && rd_data == 64'h0, "R10", "reset state",
            {rd_data[60:0], req_ready, done, bus_valid}, 64'h4);

        // directed cases
        run_req(1'b0, 2'd0, 24'h000000, 64'h0);              // R1
        run_req(1'b1, 2'd0, 24'h000000, 64'h0);              // R3 -> 0xC0
        run_req(1'b1, 2'd0, 24'h000080, 64'h0);              // R3 -> 0xC0
        run_req(1'b1, 2'd0, 24'h000148, 64'h0);              // R3 -> 0x28
        run_req(1'b1, 2'd0, 24'h000200, 64'h0);              // R3 -> 0x28
        run_req(1'b1, 2'd0, 24'h000100, 64'h0);              // R4, R5
        run_req(1'b1, 2'd1, 24'h000300, 64'h1234_5678_9ABC_DEF0); // R12, R5
        run_req(1'b1, 2'd0, 24'h044FF8, 64'h0);              // R2 last guarded
        run_req(1'b1, 2'd0, 24'h045000, 64'h0);              // R2 first unguarded
        run_req(1'b1, 2'd2, 24'h000148, 64'h00F0_0000_0000_000F); // R7
        run_req(1'b1, 2'd3, 24'h000100, 64'hFF00_0000_0000_00FF); // R8
        run_req(1'b0, 2'd3, 24'h000080, 64'h0000_FFFF_0000_0000); // R8 unguarded
        run_req(1'b1, 2'd2, 24'h050000, 64'h8000_0000_0000_0001); // R7, R2

        // random mix
        for (int n = 0; n < 80; n++) begin
            case ($urandom % 6)
                0: off = 24'h000000;
                1: off = 24'h000100;
                2: off = (($urandom % 2) == 0) ? 24'h000148 : 24'h000200;
                3: off = 24'(($urandom % 32'h45000) & ~32'h7);
                4: off = 24'(32'h45000 + (($urandom % 32'h10000) & ~32'h7));
                default: off = 24'h000080;
            endcase
            run_req(1'($urandom % 2), 2'($urandom % 4), off,
                    {$urandom, $urandom});
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule